// File: doc/BRIEF.md
# NVM Image Checksum Engine

This block walks a 16-bit, word-addressed non-volatile memory image and produces its integrity checksum. It reads through a simple request/response port that carries one read at a time. First it adds up a fixed header region. It then visits a table of pointer words, each naming a variable-length section, checks each pointer and each length, and adds the section contents to the running total. The checksum is a fixed base value minus that 16-bit total.

A start pulse launches one pass. On that pulse the block samples a mode input and an image size exponent. In compute mode it only reports the checksum. In validate mode it also compares the result with the checksum word stored in the image and flags any difference. A read that returns an error ends the pass at once. A one-cycle done pulse marks the end of every pass, whether it completes or aborts. The result outputs hold their values until the next pass ends.

Top module: `nvm_csum_engine`

## Requirements
- R1: After a start, the first 64 reads fetch addresses 0x00 to 0x3F in rising order. Every one of those words is added to the sum except the word at 0x3F, which is the stored checksum.
- R2: Pointer words are read from table slots 0x3 and 0x6 to 0xE. Slots 0x4, 0x5 and 0xF do not contribute to the result.
- R3: A pointer is discarded when it is 0x0000, is 0xFFFF, or is not below the image word size.
- R4: The word at the pointer address is the section length and is never summed. A section is discarded when its length is 0x0000 or 0xFFFF, or when pointer+length is not below the word size. Otherwise the words at pointer+1 through pointer+length, inclusive, are summed.
- R5: The reported checksum equals 0xBABA minus the 16-bit running sum, modulo 2^16.
- R6: The image word size is 1 << (size_exp + 6), sampled at start. No read address reaches or exceeds it.
- R7: A response with rd_err high ends the pass. It gives a done pulse with read_error=1, checksum=0 and mismatch=0, and no further reads are issued.
- R8: In validate mode (validate=1), mismatch is 1 exactly when the word stored at 0x3F differs from the computed checksum. In compute mode (validate=0), mismatch is 0.
- R9: rd_req is a one-cycle pulse, and no new request is made until rd_valid returns for the previous one.
- R10: done is a one-cycle pulse, and there is exactly one per accepted start. A start that arrives while a pass is running is ignored.
- R11: After reset, done, rd_req, checksum, mismatch and read_error are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| validate | input | 1 | 1 = compare with stored word, 0 = compute only |
| size_exp | input | 4 | Image size exponent; word size = 1 << (size_exp + 6) |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | 16 | Word address of the request |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | 16 | Read response word |
| rd_err | input | 1 | Response carries an error, qualified by rd_valid |
| done | output | 1 | One-cycle end-of-pass pulse |
| checksum | output | 16 | Computed checksum of the last pass |
| mismatch | output | 1 | Validate-mode comparison failed |
| read_error | output | 1 | Last pass aborted on a read error |

## Verification
The assertions check the read handshake on every cycle: a single outstanding request, one-cycle request and done pulses, and no done while a read is in flight. They also check that an error response is followed at once by an aborting done with cleared results, and that mismatch only rises together with done. Other behaviour only shows up in the bench's scenarios against an independent reference walk of the same memory image. That covers the summed header range, the skipped slots, each pointer and length rejection including the pointer+length boundary, the dependence on the size exponent, the validate result and the ignored busy start.

// File: rtl/nvm_csum_pkg.sv
// Shared constants and state type for the NVM image checksum engine.
package nvm_csum_pkg;

    // Sequencer states: each read uses a request state and a wait state.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR_REQ,
        ST_HDR_WAIT,
        ST_PTR_REQ,
        ST_PTR_WAIT,
        ST_LEN_REQ,
        ST_LEN_WAIT,
        ST_SEC_REQ,
        ST_SEC_WAIT,
        ST_FINISH
    } nvm_state_e;

    // First and last pointer-table slot visited, and slots inside that span to pass over.
    localparam int          SLOT_FIRST = 3;
    localparam int          SLOT_LAST  = 14;
    localparam logic [15:0] SLOT_SKIP  = 16'h0030;

    // Base value from which the running sum is subtracted.
    localparam logic [15:0] CSUM_BASE  = 16'hBABA;

endpackage

// File: rtl/nvm_csum_span_check.sv
// Validity checks for a pointer-table entry and the section it names.
// Assumes ws is the image word size, a power of two wider than a word address.
module nvm_csum_span_check #(
    parameter int ADDR_W = 16,
    parameter int WS_W   = 22
) (
    input  logic [WS_W-1:0]   ws,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] len,
    output logic              ptr_ok,
    output logic              len_ok
);
    localparam int SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0] span_end;

    // Pointer must be non-zero, not all ones, and inside the image.
    always_comb begin
        ptr_ok = (ptr != '0) && (ptr != '1) && (WS_W'(ptr) < ws);
    end

    // Length must be non-zero, not all ones, and the section end must stay inside the image.
    always_comb begin
        span_end = SUM_W'(ptr) + SUM_W'(len);
        len_ok   = (len != '0) && (len != '1) && (WS_W'(span_end) < ws);
    end
endmodule

// File: rtl/nvm_csum_slot_walker.sv
// Steps through pointer-table slot indices from FIRST to LAST and passes over
// every slot whose bit is set in SKIP. Assumes FIRST itself is not skipped.
module nvm_csum_slot_walker #(
    parameter int          SLOT_W = 4,
    parameter int          FIRST  = 3,
    parameter int          LAST   = 14,
    parameter logic [15:0] SKIP   = 16'h0030
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    output logic [SLOT_W-1:0] slot,
    output logic              is_last
);
    localparam int NSLOT = 1 << SLOT_W;

    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] slot_nxt;
    logic              found;

    // Pick the next slot above the current one that is in range and not skipped.
    always_comb begin
        slot_nxt = slot_q;
        found    = 1'b0;
        for (int k = 0; k < NSLOT; k++) begin
            if (!found && (k > int'(slot_q)) && (k <= LAST) && !SKIP[k]) begin
                slot_nxt = SLOT_W'(k);
                found    = 1'b1;
            end
        end
    end

    // Slot register: reload at the start of a pass, advance on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SLOT_W'(FIRST);
        end else if (load) begin
            slot_q <= SLOT_W'(FIRST);
        end else if (step) begin
            slot_q <= slot_nxt;
        end
    end

    assign slot    = slot_q;
    assign is_last = (int'(slot_q) == LAST);
endmodule

// File: rtl/nvm_csum_accum.sv
// 16-bit wrap-around accumulator, and the final checksum as BASE minus the sum.
module nvm_csum_accum #(
    parameter int                DATA_W = 16,
    parameter logic [DATA_W-1:0] BASE   = 16'hBABA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add_en,
    input  logic [DATA_W-1:0] add_val,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] sum_q;

    // Running sum, modulo 2^DATA_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (clear) begin
            sum_q <= '0;
        end else if (add_en) begin
            sum_q <= sum_q + add_val;
        end
    end

    // Checksum derived from the current sum.
    always_comb begin
        result = BASE - sum_q;
    end
endmodule

// File: rtl/nvm_csum_engine.sv
// NVM image checksum sequencer. It sums a header region, follows pointer-table
// slots to length-prefixed sections, and reports BASE minus the sum.
// Assumes one read in flight at a time and that the memory answers every
// request with exactly one rd_valid pulse.
module nvm_csum_engine
    import nvm_csum_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int EXP_W      = 4,
    parameter int SIZE_SHIFT = 6,
    parameter int HDR_WORDS  = 64,
    parameter int SLOT_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              validate,
    input  logic [EXP_W-1:0]  size_exp,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_err,
    output logic              done,
    output logic [DATA_W-1:0] checksum,
    output logic              mismatch,
    output logic              read_error
);
    localparam int WS_W  = (1 << EXP_W) + SIZE_SHIFT;
    localparam int HDR_W = $clog2(HDR_WORDS);
    localparam int SEC_W = ADDR_W + 1;
    localparam logic [HDR_W-1:0] HDR_CSUM = HDR_W'(HDR_WORDS - 1);

    nvm_state_e         state_q;
    logic [HDR_W-1:0]   hdr_idx_q;
    logic [ADDR_W-1:0]  ptr_q;
    logic [SEC_W-1:0]   sec_addr_q;
    logic [SEC_W-1:0]   sec_end_q;
    logic [DATA_W-1:0]  stored_q;
    logic               mode_q;
    logic [WS_W-1:0]    ws_q;
    logic               done_q;
    logic [DATA_W-1:0]  csum_q;
    logic               mism_q;
    logic               rerr_q;

    logic               accepted;
    logic               rsp_ok;
    logic               rsp_bad;
    logic               hdr_is_csum;
    logic               sec_last;
    logic [ADDR_W-1:0]  chk_ptr;
    logic [ADDR_W-1:0]  rsp_word;
    logic               ptr_ok;
    logic               len_ok;
    logic               slot_step;
    logic [SLOT_W-1:0]  slot;
    logic               slot_is_last;
    logic               add_en;
    logic [DATA_W-1:0]  result;

    // Decode of the response and of the start handshake.
    always_comb begin
        accepted    = (state_q == ST_IDLE) && start;
        rsp_ok      = rd_valid && !rd_err;
        rsp_bad     = rd_valid && rd_err;
        hdr_is_csum = (hdr_idx_q == HDR_CSUM);
        sec_last    = (sec_addr_q == sec_end_q);
        rsp_word    = ADDR_W'(rd_data);
        chk_ptr     = (state_q == ST_PTR_WAIT) ? rsp_word : ptr_q;
    end

    // Conditions that end work on the current slot and move to the next one.
    always_comb begin
        slot_step = 1'b0;
        case (state_q)
            ST_PTR_WAIT: slot_step = rsp_ok && !ptr_ok;
            ST_LEN_WAIT: slot_step = rsp_ok && !len_ok;
            ST_SEC_WAIT: slot_step = rsp_ok && sec_last;
            default:     slot_step = 1'b0;
        endcase
    end

    // Words that enter the sum: the header except the stored checksum, and section bodies.
    always_comb begin
        add_en = ((state_q == ST_HDR_WAIT) && rsp_ok && !hdr_is_csum) ||
                 ((state_q == ST_SEC_WAIT) && rsp_ok);
    end

    nvm_csum_span_check #(
        .ADDR_W (ADDR_W),
        .WS_W   (WS_W)
    ) span_i (
        .ws     (ws_q),
        .ptr    (chk_ptr),
        .len    (rsp_word),
        .ptr_ok (ptr_ok),
        .len_ok (len_ok)
    );

    nvm_csum_slot_walker #(
        .SLOT_W (SLOT_W),
        .FIRST  (SLOT_FIRST),
        .LAST   (SLOT_LAST),
        .SKIP   (SLOT_SKIP)
    ) walker_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accepted),
        .step    (slot_step),
        .slot    (slot),
        .is_last (slot_is_last)
    );

    nvm_csum_accum #(
        .DATA_W (DATA_W),
        .BASE   (DATA_W'(CSUM_BASE))
    ) accum_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accepted),
        .add_en  (add_en),
        .add_val (rd_data),
        .result  (result)
    );

    // Read request and address for the current request state.
    always_comb begin
        rd_req  = 1'b0;
        rd_addr = '0;
        case (state_q)
            ST_HDR_REQ: begin rd_req = 1'b1; rd_addr = ADDR_W'(hdr_idx_q); end
            ST_PTR_REQ: begin rd_req = 1'b1; rd_addr = ADDR_W'(slot); end
            ST_LEN_REQ: begin rd_req = 1'b1; rd_addr = ptr_q; end
            ST_SEC_REQ: begin rd_req = 1'b1; rd_addr = sec_addr_q[ADDR_W-1:0]; end
            default:    begin rd_req = 1'b0; rd_addr = '0; end
        endcase
    end

    // Main sequencer: header walk, pointer walk, section walk, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            hdr_idx_q  <= '0;
            ptr_q      <= '0;
            sec_addr_q <= '0;
            sec_end_q  <= '0;
            stored_q   <= '0;
            mode_q     <= 1'b0;
            ws_q       <= '0;
            done_q     <= 1'b0;
            csum_q     <= '0;
            mism_q     <= 1'b0;
            rerr_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accepted) begin
                        mode_q    <= validate;
                        ws_q      <= WS_W'(1) << (int'(size_exp) + SIZE_SHIFT);
                        hdr_idx_q <= '0;
                        state_q   <= ST_HDR_REQ;
                    end
                end
                ST_HDR_REQ: state_q <= ST_HDR_WAIT;
                ST_HDR_WAIT: begin
                    if (rsp_ok) begin
                        if (hdr_is_csum) begin
                            stored_q <= rd_data;
                            state_q  <= ST_PTR_REQ;
                        end else begin
                            hdr_idx_q <= hdr_idx_q + 1'b1;
                            state_q   <= ST_HDR_REQ;
                        end
                    end
                end
                ST_PTR_REQ: state_q <= ST_PTR_WAIT;
                ST_PTR_WAIT: begin
                    if (rsp_ok) begin
                        if (ptr_ok) begin
                            ptr_q   <= rsp_word;
                            state_q <= ST_LEN_REQ;
                        end else begin
                            state_q <= slot_is_last ? ST_FINISH : ST_PTR_REQ;
                        end
                    end
                end
                ST_LEN_REQ: state_q <= ST_LEN_WAIT;
                ST_LEN_WAIT: begin
                    if (rsp_ok) begin
                        if (len_ok) begin
                            sec_addr_q <= SEC_W'(ptr_q) + SEC_W'(1);
                            sec_end_q  <= SEC_W'(ptr_q) + SEC_W'(rsp_word);
                            state_q    <= ST_SEC_REQ;
                        end else begin
                            state_q <= slot_is_last ? ST_FINISH : ST_PTR_REQ;
                        end
                    end
                end
                ST_SEC_REQ: state_q <= ST_SEC_WAIT;
                ST_SEC_WAIT: begin
                    if (rsp_ok) begin
                        if (sec_last) begin
                            state_q <= slot_is_last ? ST_FINISH : ST_PTR_REQ;
                        end else begin
                            sec_addr_q <= sec_addr_q + 1'b1;
                            state_q    <= ST_SEC_REQ;
                        end
                    end
                end
                ST_FINISH: begin
                    done_q  <= 1'b1;
                    csum_q  <= result;
                    mism_q  <= mode_q && (stored_q != result);
                    rerr_q  <= 1'b0;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase

            // Abort on any failed response, whatever wait state the pass is in.
            if (rsp_bad && (state_q != ST_IDLE)) begin
                done_q  <= 1'b1;
                csum_q  <= '0;
                mism_q  <= 1'b0;
                rerr_q  <= 1'b1;
                state_q <= ST_IDLE;
            end
        end
    end

    assign done       = done_q;
    assign checksum   = csum_q;
    assign mismatch   = mism_q;
    assign read_error = rerr_q;
endmodule

// File: rtl/nvm_csum_engine_chk.sv
// Protocol checker for nvm_csum_engine, attached with bind below.
// Tracks the outstanding read from the port signals alone.
module nvm_csum_engine_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              rd_valid,
    input logic              rd_err,
    input logic              done,
    input logic [DATA_W-1:0] checksum,
    input logic              mismatch,
    input logic              read_error
);
    logic pend_q;

    // Outstanding-read flag seen from the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (rd_req) begin
            pend_q <= 1'b1;
        end else if (rd_valid) begin
            pend_q <= 1'b0;
        end
    end

    // R9: no new request while one is in flight.
    a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !rd_req);

    // R9: a request lasts one cycle.
    a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R10: done lasts one cycle.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a pass never ends with a read still in flight.
    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !pend_q);

    // R7: an error response ends the pass on the next cycle.
    a_r7_error_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_err) |=> (done && read_error));

    // R7: an aborted pass reports cleared results.
    a_r7_error_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done && read_error) |-> ((checksum == '0) && !mismatch));

    // R8: mismatch only changes to set together with a done pulse.
    a_r8_mismatch_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mismatch) |-> done);
endmodule

bind nvm_csum_engine nvm_csum_engine_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .rd_valid   (rd_valid),
    .rd_err     (rd_err),
    .done       (done),
    .checksum   (checksum),
    .mismatch   (mismatch),
    .read_error (read_error)
);

// File: tb/nvm_csum_engine_tb_top.sv
// Scoreboard bench: a reference walk of the memory image pushes the expected
// result, and a monitor compares it with each done pulse.
module nvm_csum_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        validate = 1'b0;
    logic [3:0]  size_exp = 4'd3;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_data = '0;
    logic        rd_err = 1'b0;
    logic        done;
    logic [15:0] checksum;
    logic        mismatch;
    logic        read_error;

    always #10 clk = ~clk;

    nvm_csum_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .validate(validate),
        .size_exp(size_exp), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
        .done(done), .checksum(checksum), .mismatch(mismatch),
        .read_error(read_error)
    );

    typedef struct {
        logic [15:0] cs;
        bit          mm;
        bit          er;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [15:0] mem [0:1023];
    int          err_addr = -1;
    int          total = 0;
    int          bad = 0;
    int          done_cnt = 0;
    int          req_total = 0;
    int          req_idx = 0;
    int          hdr_bad = 0;
    int          addr_bad = 0;
    int          overlap = 0;
    int          size_cur = 512;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory model: one read at a time, latency set by the low address bits.
    logic        mm_active = 1'b0;
    logic [9:0]  mm_addr = '0;
    int          mm_wait = 0;
    always @(posedge clk) begin
        rd_valid <= 1'b0;
        rd_err   <= 1'b0;
        if (rd_req) begin
            mm_addr   <= rd_addr[9:0];
            mm_wait   <= int'(rd_addr[1:0]);
            mm_active <= 1'b1;
        end else if (mm_active) begin
            if (mm_wait == 0) begin
                rd_valid  <= 1'b1;
                rd_data   <= mem[mm_addr];
                rd_err    <= (int'(mm_addr) == err_addr);
                mm_active <= 1'b0;
            end else begin
                mm_wait <= mm_wait - 1;
            end
        end
    end

    // Request monitor: header order (R1), address range (R6), overlap (R9).
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req) begin
                if (req_idx < 64 && int'(rd_addr) != req_idx) hdr_bad++;
                if (int'(rd_addr) >= size_cur) addr_bad++;
                if (mm_active) overlap++;
                req_idx++;
                req_total++;
            end
        end
    end

    // Result monitor: pop the expected item on each done pulse and compare.
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                done_cnt++;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(checksum == e.cs, "R5", {e.tag, " checksum"}, 32'(checksum), 32'(e.cs));
                    chk(mismatch == e.mm, "R8", {e.tag, " mismatch"}, 32'(mismatch), 32'(e.mm));
                    chk(read_error == e.er, "R7", {e.tag, " read_error"}, 32'(read_error), 32'(e.er));
                end
                @(negedge clk);
                chk(!done, "R10", "done lasts one cycle", 32'(done), 32'd0);
            end
        end
    end

    // Reference walk of the image, written from the requirements.
    task automatic ref_run(input int exp, input bit val, output exp_t e);
        int          size;
        logic [15:0] sum;
        logic [15:0] stored;
        logic [15:0] p;
        logic [15:0] l;
        size   = 1 << (exp + 6);
        sum    = '0;
        stored = '0;
        e.er   = 1'b0;
        e.mm   = 1'b0;
        e.cs   = '0;
        for (int a = 0; a < 64; a++) begin
            if (a == err_addr) begin e.er = 1'b1; return; end
            if (a == 63) stored = mem[a];
            else sum = sum + mem[a];
        end
        for (int s = 3; s < 15; s++) begin
            if (s == 4 || s == 5) continue;
            if (s == err_addr) begin e.er = 1'b1; return; end
            p = mem[s];
            if (p == 16'hFFFF || p == 16'h0000 || int'(p) >= size) continue;
            if (int'(p) == err_addr) begin e.er = 1'b1; return; end
            l = mem[p[9:0]];
            if (l == 16'hFFFF || l == 16'h0000 || (int'(p) + int'(l)) >= size) continue;
            for (int j = int'(p) + 1; j <= int'(p) + int'(l); j++) begin
                if (j == err_addr) begin e.er = 1'b1; return; end
                sum = sum + mem[j];
            end
        end
        e.cs = 16'hBABA - sum;
        e.mm = val && (stored != e.cs);
    endtask

    // Driver: push the expectation, pulse start, wait for the done pulse.
    task automatic run_case(input int exp, input bit val, input string tag);
        exp_t e;
        int   prev;
        int   n;
        ref_run(exp, val, e);
        e.tag = tag;
        sb_q.push_back(e);
        size_cur = 1 << (exp + 6);
        req_idx  = 0;
        prev     = done_cnt;
        @(negedge clk);
        size_exp = 4'(exp);
        validate = val;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (done_cnt == prev && n < 20000) begin
            @(posedge clk);
            n++;
        end
        chk(done_cnt == prev + 1, "R10", {tag, " one done per start"}, 32'(done_cnt - prev), 32'd1);
    endtask

    // Image with a counting header, distinct fill, and empty pointer slots.
    task automatic base_image(input logic [15:0] seed);
        for (int a = 0; a < 1024; a++) mem[a] = 16'(a * 16'h0123) ^ seed;
        for (int s = 3; s < 16; s++) mem[s] = 16'hFFFF;
        err_addr = -1;
    endtask

    // Rich image: valid sections, each rejection rule, and skipped slots.
    task automatic rich_image();
        base_image(16'h5A3C);
        mem[3]  = 16'h0080; mem[16'h080] = 16'd5;     // valid section
        mem[6]  = 16'h0100; mem[16'h100] = 16'd3;     // valid, >= 256
        mem[7]  = 16'h0000;                           // R3 zero pointer
        mem[8]  = 16'hFFFF;                           // R3 all-ones pointer
        mem[9]  = 16'h0200; mem[16'h200] = 16'd4;     // R3 equals 512, R6 valid at 1024
        mem[10] = 16'h0090; mem[16'h090] = 16'h0000;  // R4 zero length
        mem[11] = 16'h00A0; mem[16'h0A0] = 16'hFFFF;  // R4 all-ones length
        mem[12] = 16'h01E0; mem[16'h1E0] = 16'h0020;  // R4 ends at 512: rejected
        mem[13] = 16'h01F0; mem[16'h1F0] = 16'h000F;  // R4 ends at 511: kept
        mem[14] = 16'h00C0; mem[16'h0C0] = 16'd2;     // last slot
        mem[4]  = 16'h00D0; mem[16'h0D0] = 16'd4;     // R2 skipped slot
        mem[5]  = 16'h00E0; mem[16'h0E0] = 16'd4;     // R2 skipped slot
        mem[15] = 16'h00F0; mem[16'h0F0] = 16'd4;     // R2 past last slot
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "R10", "watchdog expired", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        exp_t tmp;
        int   r0;
        int   prev;
        base_image(16'h1111);
        repeat (3) @(negedge clk);
        // R11: outputs after reset.
        chk(done == 1'b0, "R11", "done after reset", 32'(done), 32'd0);
        chk(rd_req == 1'b0, "R11", "rd_req after reset", 32'(rd_req), 32'd0);
        chk(checksum == 16'h0, "R11", "checksum after reset", 32'(checksum), 32'd0);
        chk(mismatch == 1'b0, "R11", "mismatch after reset", 32'(mismatch), 32'd0);
        chk(read_error == 1'b0, "R11", "read_error after reset", 32'(read_error), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R5: header only, all slots empty.
        run_case(3, 1'b0, "R1 header only");
        chk(hdr_bad == 0, "R1", "header read order", 32'(hdr_bad), 32'd0);

        // R2 R3 R4: every rejection rule and skipped slot, compute mode.
        rich_image();
        run_case(3, 1'b0, "R2 R3 R4 rich image");

        // R8: validate with the matching stored word.
        ref_run(3, 1'b0, tmp);
        mem[63] = tmp.cs;
        run_case(3, 1'b1, "R8 validate match");

        // R8: validate with a wrong stored word.
        mem[63] = tmp.cs ^ 16'h0101;
        run_case(3, 1'b1, "R8 validate mismatch");

        // R8: compute mode ignores a wrong stored word.
        run_case(3, 1'b0, "R8 compute mode");

        // R6: smaller and larger images change which pointers are accepted.
        run_case(2, 1'b0, "R6 size 256");
        run_case(4, 1'b0, "R6 size 1024");

        // R7: error inside a section, then silence on the read port.
        err_addr = 16'h0082;
        run_case(3, 1'b0, "R7 section error");
        r0 = req_total;
        repeat (10) @(posedge clk);
        chk(req_total == r0, "R7", "no reads after abort", 32'(req_total - r0), 32'd0);

        // R7: error inside the header.
        err_addr = 5;
        run_case(3, 1'b1, "R7 header error");
        err_addr = -1;

        // R10: start while busy is ignored.
        rich_image();
        begin
            exp_t e;
            int   n;
            ref_run(3, 1'b1, e);
            e.tag = "R10 busy start";
            sb_q.push_back(e);
            size_cur = 512;
            req_idx  = 0;
            prev     = done_cnt;
            @(negedge clk);
            size_exp = 4'd3; validate = 1'b1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (30) @(negedge clk);
            size_exp = 4'd2; validate = 1'b0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            n = 0;
            while (done_cnt == prev && n < 20000) begin
                @(posedge clk);
                n++;
            end
            repeat (40) @(posedge clk);
            chk(done_cnt == prev + 1, "R10", "busy start ignored", 32'(done_cnt - prev), 32'd1);
        end

        chk(sb_q.size() == 0, "R10", "all results produced", 32'(sb_q.size()), 32'd0);
        chk(addr_bad == 0, "R6", "reads inside image", 32'(addr_bad), 32'd0);
        chk(overlap == 0, "R9", "single outstanding read", 32'(overlap), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule